// File: doc/BRIEF.md
# Cursor Overlay Engine

The engine places a small pointer image over a live pixel stream. A display timing source hands it one background pixel per clock together with that pixel's screen coordinates and a data-enable flag. Wherever the pixel falls inside the cursor rectangle, the engine fetches the matching cursor word from its image store. It then mixes that word into the background under a per-pixel transparency code. Each output pixel appears two clocks after its input.

The host loads the image and the transparency store through a single write port, and programs a position, a bitmap size and an enable bit. Position, size and enable go into shadow registers. They reach the drawing logic only at the next frame-end pulse, so a frame never shows a half-updated cursor. The transparency store has a sleep input. On every wake, and after reset, the engine refills the store with a default pattern before the cursor may appear again.

Top module: `cursor_overlay`

## Requirements
- R1: While and right after reset, out_valid and out_rgb are zero and no cursor is drawn until the host enables one and a frame end occurs.
- R2: out_valid equals pix_valid delayed by two clocks. out_rgb is zero when out_valid is low. Outside the cursor, out_rgb equals bg_rgb delayed by two clocks.
- R3: Each image word packs alpha in bits 31:24, blue in 23:16, green in 15:8 and red in 7:0. For blend pixels, each channel is floor((a*cursor + (255-a)*background)/255). Alpha 0 returns the background and alpha 255 returns the cursor colour. bg_rgb and out_rgb carry red in 23:16, green in 15:8 and blue in 7:0.
- R4: Writes to position, size and enable change nothing on screen until the next frame_end pulse, which copies all three at once.
- R5: A size write whose width field or height field is zero turns the drawn cursor off from the following clock, without waiting for frame_end.
- R6: At frame_end, a shadow size is rejected and the active size, position and enable are kept if either dimension exceeds LONG or both exceed SHORT. Sizes of LONG by SHORT and SHORT by LONG are accepted.
- R7: wr_sel selects the target: 0 image word at wr_addr, 1 transparency word at wr_addr, 2 position, 3 size, 4 control. Position holds signed y in 31:16 and signed x in 15:0. Size holds height in 31:16 and width in 15:0. Control bit 0 is the enable.
- R8: The image is row-major with a row stride equal to the programmed width, so screen pixel (x,y) reads word (y-posy)*width + (x-posx). With a negative position the first drawn pixel starts at that offset. Parts beyond the active area are never shown.
- R9: With interlace high, only the first floor(height/2) bitmap rows are drawn.
- R10: The transparency code of image word n sits in bits 2*(n%16)+1:2*(n%16) of transparency word n/16. Code 00 shows the background, 01 blends by alpha, 10 and 11 show the cursor colour opaquely.
- R11: After reset and after each fall of ram_sleep, all TRAN_DEPTH transparency words are set to 0x55555555, one per clock. Nothing is drawn while ram_sleep is high or the refill is running, and host transparency writes in that time are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Write target select |
| wr_addr | input | WA_W | Word address for image or transparency writes |
| wr_data | input | 32 | Write data |
| frame_end | input | 1 | One-clock pulse at the end of each frame |
| interlace | input | 1 | Output is interlaced; halve drawn height |
| ram_sleep | input | 1 | Transparency store powered down |
| pix_valid | input | 1 | Active-video flag for this pixel |
| pix_x | input | 16 | Screen column of this pixel |
| pix_y | input | 16 | Screen row of this pixel |
| bg_rgb | input | 24 | Background pixel |
| out_valid | output | 1 | Active-video flag of the output pixel |
| out_rgb | output | 24 | Composited pixel |

## Verification
The bench builds the engine with LONG=8, SHORT=4 and TRAN_DEPTH=4 on a 16 by 8 screen. A whole frame then takes about 140 clocks, and every image word is read many times. Both cursor orientations, oversize rejection and clipping at all four edges fit into a few frames. The four-word refill is short enough for sleep and wake to land mid-frame, with the refill's end visible on screen.

// File: rtl/cursor_pkg.sv
// Shared encodings and the per-channel blend used by the cursor overlay.
// Assumes 8-bit colour channels and 32-bit host data.
package cursor_pkg;

    typedef enum logic [2:0] {
        SEL_IMG  = 3'd0,
        SEL_TRAN = 3'd1,
        SEL_POS  = 3'd2,
        SEL_SIZE = 3'd3,
        SEL_CTRL = 3'd4
    } wsel_e;

    typedef enum logic [1:0] {
        TC_CLEAR = 2'b00,
        TC_BLEND = 2'b01,
        TC_OPAQ0 = 2'b10,
        TC_OPAQ1 = 2'b11
    } tcode_e;

    localparam logic [31:0] TRAN_FILL = 32'h5555_5555;

    // floor((a*c + (255-a)*b)/255) without a divider
    function automatic logic [7:0] mix8(input logic [7:0] a, input logic [7:0] c,
                                        input logic [7:0] b);
        logic [15:0] s;
        logic [16:0] t;
        s = 16'(a) * 16'(c) + 16'(8'd255 - a) * 16'(b);
        t = {1'b0, s} + {9'b0, s[15:8]} + 17'd1;
        return t[15:8];
    endfunction

endpackage

// File: rtl/cursor_ctrl.sv
// Shadow and active copies of cursor position, size and enable.
// Shadows take host writes; actives load at frame_end when the shadow
// size is legal. A zero width or height write drops the active enable at once.
module cursor_ctrl #(
    parameter int LONG  = 64,
    parameter int SHORT = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic        frame_end,
    output logic [31:0] act_pos,
    output logic [31:0] act_size,
    output logic        act_en
);
    import cursor_pkg::*;

    logic [31:0] sh_pos;
    logic [31:0] sh_size;
    logic        sh_en;
    logic        sh_legal;
    logic        zero_wr;

    // Legality of the pending size: no side above LONG, not both above SHORT
    always_comb begin
        sh_legal = (sh_size[15:0] <= 16'(LONG)) && (sh_size[31:16] <= 16'(LONG)) &&
                   !((sh_size[15:0] > 16'(SHORT)) && (sh_size[31:16] > 16'(SHORT)));
        zero_wr  = wr_en && (wr_sel == SEL_SIZE) &&
                   ((wr_data[15:0] == 16'd0) || (wr_data[31:16] == 16'd0));
    end

    // Shadow registers follow host writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_pos  <= '0;
            sh_size <= '0;
            sh_en   <= 1'b0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_POS:  sh_pos  <= wr_data;
                SEL_SIZE: sh_size <= wr_data;
                SEL_CTRL: sh_en   <= wr_data[0];
                default:  ;
            endcase
        end
    end

    // Active registers load at frame end; zero size disables immediately
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_pos  <= '0;
            act_size <= '0;
            act_en   <= 1'b0;
        end else begin
            if (frame_end && sh_legal) begin
                act_pos  <= sh_pos;
                act_size <= sh_size;
                act_en   <= sh_en;
            end
            if (zero_wr) begin
                act_en <= 1'b0;
            end
        end
    end

    AST_ZERO_SIZE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        zero_wr |=> !act_en);  // R5
    AST_HOLD_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(act_pos) && $stable(act_size)));  // R4
    AST_OVERSIZE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !sh_legal) |=> ($stable(act_size) && $stable(act_pos)));  // R6

endmodule

// File: rtl/cursor_tran.sv
// Transparency store with its wake-up refill sequencer.
// After reset or a fall of ram_sleep every word is written with the fill
// pattern, one per clock; host writes are accepted only when ready.
// Read data is registered (one clock).
module cursor_tran #(
    parameter int DEPTH = 256,
    localparam int TA_W = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ram_sleep,
    input  logic            wr_en,
    input  logic [TA_W-1:0] wr_idx,
    input  logic [31:0]     wr_word,
    input  logic [TA_W-1:0] rd_idx,
    output logic            ready,
    output logic [31:0]     rd_word
);
    import cursor_pkg::*;

    logic [31:0]     mem [DEPTH];
    logic            need_fill;
    logic            filling;
    logic [TA_W-1:0] fill_ptr;

    // Store is usable only when awake and not refilling
    always_comb ready = !ram_sleep && !need_fill && !filling;

    // Refill sequencer: sleep arms it, wake starts it, last word ends it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            need_fill <= 1'b1;
            filling   <= 1'b0;
            fill_ptr  <= '0;
        end else if (ram_sleep) begin
            need_fill <= 1'b1;
            filling   <= 1'b0;
        end else if (need_fill) begin
            need_fill <= 1'b0;
            filling   <= 1'b1;
            fill_ptr  <= '0;
        end else if (filling) begin
            fill_ptr <= fill_ptr + 1'b1;
            if (fill_ptr == TA_W'(DEPTH - 1)) begin
                filling <= 1'b0;
            end
        end
    end

    // Memory write: refill has priority, host writes only when ready
    always_ff @(posedge clk) begin
        if (rst_n && filling && !ram_sleep) begin
            mem[fill_ptr] <= TRAN_FILL;
        end else if (rst_n && wr_en && ready) begin
            mem[wr_idx] <= wr_word;
        end
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) rd_word <= '0;
        else        rd_word <= mem[rd_idx];
    end

    AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sleep |=> !ready);  // R11
    AST_WAKE_REFILLS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_sleep) |-> (!ready && need_fill));  // R11

endmodule

// File: rtl/cursor_img.sv
// Cursor image store: one host write port, one registered read port.
// Assumes the host never reads and writes the same word in one clock.
module cursor_img #(
    parameter int DEPTH = 2048,
    localparam int IA_W = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IA_W-1:0] wr_addr,
    input  logic [31:0]     wr_word,
    input  logic [IA_W-1:0] rd_addr,
    output logic [31:0]     rd_word
);
    logic [31:0] mem [DEPTH];

    // Host write into the image
    always_ff @(posedge clk) begin
        if (rst_n && wr_en) mem[wr_addr] <= wr_word;
    end

    // Registered read for the pixel pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) rd_word <= '0;
        else        rd_word <= mem[rd_addr];
    end

endmodule

// File: rtl/cursor_mix.sv
// Output stage: picks the transparency code for the fetched word and
// produces the registered output pixel (background, blend or opaque).
module cursor_mix (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_hit,
    input  logic [23:0] in_bg,
    input  logic [31:0] in_word,
    input  logic [31:0] in_tword,
    input  logic [3:0]  in_sub,
    output logic        out_valid,
    output logic [23:0] out_rgb
);
    import cursor_pkg::*;

    tcode_e      code;
    logic [23:0] pix;

    // Select transparency code and form the composited colour
    always_comb begin
        code = tcode_e'(in_tword[{in_sub, 1'b0} +: 2]);
        if (!in_hit || code == TC_CLEAR) begin
            pix = in_bg;
        end else if (code == TC_BLEND) begin
            pix = {mix8(in_word[31:24], in_word[7:0],   in_bg[23:16]),
                   mix8(in_word[31:24], in_word[15:8],  in_bg[15:8]),
                   mix8(in_word[31:24], in_word[23:16], in_bg[7:0])};
        end else begin
            pix = {in_word[7:0], in_word[15:8], in_word[23:16]};
        end
    end

    // Output register, blanked outside active video
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= in_valid;
            out_rgb   <= in_valid ? pix : 24'd0;
        end
    end

    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && out_rgb == 24'd0));  // R2
    AST_MISS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_hit) |=> (out_valid && out_rgb == $past(in_bg)));  // R2
    AST_ALPHA0_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_hit && code == TC_BLEND && in_word[31:24] == 8'd0)
        |=> (out_rgb == $past(in_bg)));  // R3

endmodule

// File: rtl/cursor_overlay.sv
// Top of the cursor overlay. Stage 1 decides whether the incoming pixel
// lies inside the active cursor rectangle and fetches the image and
// transparency words; stage 2 composites. Assumes pix_x/pix_y come from
// the display timing source aligned with bg_rgb and pix_valid.
module cursor_overlay #(
    parameter int LONG       = 64,
    parameter int SHORT      = 32,
    parameter int TRAN_DEPTH = 256,
    localparam int IMG_DEPTH = LONG * SHORT,
    localparam int IA_W      = $clog2(IMG_DEPTH),
    localparam int TA_W      = $clog2(TRAN_DEPTH),
    localparam int WA_W      = (IA_W > TA_W) ? IA_W : TA_W,
    localparam int DIM_W     = $clog2(LONG + 1),
    localparam int PW        = 2 * DIM_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      wr_sel,
    input  logic [WA_W-1:0] wr_addr,
    input  logic [31:0]     wr_data,
    input  logic            frame_end,
    input  logic            interlace,
    input  logic            ram_sleep,
    input  logic            pix_valid,
    input  logic [15:0]     pix_x,
    input  logic [15:0]     pix_y,
    input  logic [23:0]     bg_rgb,
    output logic            out_valid,
    output logic [23:0]     out_rgb
);
    import cursor_pkg::*;

    logic [31:0]        act_pos;
    logic [31:0]        act_size;
    logic               act_en;
    logic               tran_ready;
    logic signed [17:0] dx;
    logic signed [17:0] dy;
    logic [15:0]        h_eff;
    logic [PW-1:0]      lin;
    logic [IA_W-1:0]    img_addr;
    logic               hit;
    logic [31:0]        img_word;
    logic [31:0]        tran_word;
    logic               v1;
    logic               hit1;
    logic [23:0]        bg1;
    logic [3:0]         sub1;

    cursor_ctrl #(.LONG(LONG), .SHORT(SHORT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .frame_end(frame_end),
        .act_pos(act_pos), .act_size(act_size), .act_en(act_en)
    );

    // Offsets into the bitmap, drawn height and row-major address
    always_comb begin
        dx    = $signed({2'b00, pix_x}) - $signed({{2{act_pos[15]}}, act_pos[15:0]});
        dy    = $signed({2'b00, pix_y}) - $signed({{2{act_pos[31]}}, act_pos[31:16]});
        h_eff = interlace ? (act_size[31:16] >> 1) : act_size[31:16];
        lin   = PW'(dy[DIM_W-1:0]) * PW'(act_size[DIM_W-1:0]) + PW'(dx[DIM_W-1:0]);
        img_addr = IA_W'(lin);
        hit   = pix_valid && act_en && tran_ready &&
                !dx[17] && (dx[16:0] < {1'b0, act_size[15:0]}) &&
                !dy[17] && (dy[16:0] < {1'b0, h_eff});
    end

    cursor_img #(.DEPTH(IMG_DEPTH)) u_img (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en && wr_sel == SEL_IMG), .wr_addr(IA_W'(wr_addr)),
        .wr_word(wr_data), .rd_addr(img_addr), .rd_word(img_word)
    );

    cursor_tran #(.DEPTH(TRAN_DEPTH)) u_tran (
        .clk(clk), .rst_n(rst_n), .ram_sleep(ram_sleep),
        .wr_en(wr_en && wr_sel == SEL_TRAN), .wr_idx(TA_W'(wr_addr)),
        .wr_word(wr_data), .rd_idx(TA_W'(img_addr >> 4)),
        .ready(tran_ready), .rd_word(tran_word)
    );

    // Stage 1 pipeline registers alongside the memory reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1   <= 1'b0;
            hit1 <= 1'b0;
            bg1  <= '0;
            sub1 <= '0;
        end else begin
            v1   <= pix_valid;
            hit1 <= hit;
            bg1  <= bg_rgb;
            sub1 <= img_addr[3:0];
        end
    end

    cursor_mix u_mix (
        .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_hit(hit1), .in_bg(bg1),
        .in_word(img_word), .in_tword(tran_word), .in_sub(sub1),
        .out_valid(out_valid), .out_rgb(out_rgb)
    );

    AST_NO_DRAW_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sleep |-> !hit);  // R11
    AST_INTERLACE_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && interlace) |-> (dy[16:0] < {1'b0, act_size[31:17]}));  // R9

endmodule

// File: tb/tb_cursor_overlay.sv
// Bench: a behavioural model updated at every rising edge predicts each
// output pixel; outputs are compared at every falling edge.
module tb_cursor_overlay;
    localparam int LONG = 8, SHORT = 4, TD = 4, IMG = LONG * SHORT;
    localparam int HACT = 16, VACT = 8, WA = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [WA-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          frame_end = 1'b0;
    logic          interlace = 1'b0;
    logic          ram_sleep = 1'b0;
    logic          pix_valid = 1'b0;
    logic [15:0]   pix_x = '0;
    logic [15:0]   pix_y = '0;
    logic [23:0]   bg_rgb = '0;
    logic          out_valid;
    logic [23:0]   out_rgb;

    always #2 clk = ~clk;

    cursor_overlay #(.LONG(LONG), .SHORT(SHORT), .TRAN_DEPTH(TD)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_end(frame_end), .interlace(interlace),
        .ram_sleep(ram_sleep), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
        .bg_rgb(bg_rgb), .out_valid(out_valid), .out_rgb(out_rgb)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string phase = "R1";

    // reference state
    logic [31:0] m_img [IMG];
    logic [31:0] m_tran [TD];
    logic [31:0] m_sh_pos, m_sh_size, m_a_pos, m_a_size;
    bit          m_sh_en, m_a_en, m_need, m_busy;
    int          m_cnt;
    logic [24:0] q [$];

    task automatic check(string tag, logic [24:0] got, logic [24:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic bit legal(logic [31:0] s);
        int w = int'(s[15:0]);
        int h = int'(s[31:16]);
        return (w <= LONG) && (h <= LONG) && !((w > SHORT) && (h > SHORT));
    endfunction

    function automatic int blend(int a, int c, int b);
        return (a * c + (255 - a) * b) / 255;
    endfunction

    function automatic logic [24:0] model_pixel();
        int px, py, w, h, dx, dy, addr, code, a;
        logic [31:0] wd;
        if (!pix_valid) return 25'd0;
        px = $signed(m_a_pos[15:0]);
        py = $signed(m_a_pos[31:16]);
        w  = int'(m_a_size[15:0]);
        h  = int'(m_a_size[31:16]);
        if (interlace) h = h / 2;
        dx = int'(pix_x) - px;
        dy = int'(pix_y) - py;
        if (!(m_a_en && !ram_sleep && !m_need && !m_busy &&
              dx >= 0 && dx < w && dy >= 0 && dy < h))
            return {1'b1, bg_rgb};
        addr = dy * w + dx;
        wd   = m_img[addr];
        code = int'((m_tran[addr / 16] >> (2 * (addr % 16))) & 32'd3);
        if (code == 0) return {1'b1, bg_rgb};
        if (code >= 2) return {1'b1, wd[7:0], wd[15:8], wd[23:16]};
        a = int'(wd[31:24]);
        return {1'b1, 8'(blend(a, int'(wd[7:0]),   int'(bg_rgb[23:16]))),
                      8'(blend(a, int'(wd[15:8]),  int'(bg_rgb[15:8]))),
                      8'(blend(a, int'(wd[23:16]), int'(bg_rgb[7:0])))};
    endfunction

    // Reference model: predict this edge's pixel, then advance state
    always @(posedge clk) begin
        if (!rst_n) begin
            q.push_back(25'd0);
            m_sh_pos = '0; m_sh_size = '0; m_sh_en = 0;
            m_a_pos = '0; m_a_size = '0; m_a_en = 0;
            m_need = 1; m_busy = 0; m_cnt = 0;
        end else begin
            bit rdy;
            rdy = !ram_sleep && !m_need && !m_busy;
            q.push_back(model_pixel());
            if (frame_end && legal(m_sh_size)) begin
                m_a_pos = m_sh_pos; m_a_size = m_sh_size; m_a_en = m_sh_en;
            end
            if (wr_en) begin
                case (wr_sel)
                    3'd0: m_img[wr_addr] = wr_data;
                    3'd1: if (rdy) m_tran[int'(wr_addr) % TD] = wr_data;
                    3'd2: m_sh_pos = wr_data;
                    3'd3: begin
                        m_sh_size = wr_data;
                        if (wr_data[15:0] == 0 || wr_data[31:16] == 0) m_a_en = 0;
                    end
                    3'd4: m_sh_en = wr_data[0];
                    default: ;
                endcase
            end
            if (ram_sleep) begin
                m_need = 1; m_busy = 0;
            end else if (m_need) begin
                m_need = 0; m_busy = 1; m_cnt = 0;
            end else if (m_busy) begin
                m_tran[m_cnt] = 32'h5555_5555;
                if (m_cnt == TD - 1) m_busy = 0;
                m_cnt++;
            end
        end
    end

    // Per-clock comparison against the prediction made two edges earlier
    always @(negedge clk) begin
        if (!done && q.size() >= 2) begin
            check(phase, {out_valid, out_rgb}, q[q.size() - 2]);
            while (q.size() > 2) void'(q.pop_front());
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            pix_valid = 0; wr_en = 0; frame_end = 0;
            @(negedge clk);
        end
    endtask

    task automatic hw(logic [2:0] sel, int addr, logic [31:0] d);
        wr_en = 1; wr_sel = sel; wr_addr = WA'(addr); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    // One frame of active video; optional zero-size write at a given line
    task automatic frame(int seed, int zero_line);
        for (int y = 0; y < VACT; y++) begin
            for (int x = 0; x < HACT; x++) begin
                pix_valid = 1; pix_x = 16'(x); pix_y = 16'(y);
                bg_rgb = 24'((x * 37 + y * 91 + seed * 13) * 2654435 + x * y);
                if (y == zero_line && x == 5) begin
                    wr_en = 1; wr_sel = 3'd3; wr_addr = '0; wr_data = {16'd0, 16'd8};
                end
                @(negedge clk);
                wr_en = 0;
            end
            pix_valid = 0;
            @(negedge clk);
        end
        frame_end = 1;
        @(negedge clk);
        frame_end = 0;
    endtask

    task automatic report();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        check("R1", {out_valid, out_rgb}, 25'd0);  // R1 reset state
        rst_n = 1;
        idle(TD + 4);
        phase = "R1";
        frame(1, -1);                                // R1 nothing drawn yet
        phase = "R7";
        for (int i = 0; i < IMG; i++) begin
            logic [7:0] a;
            a = (i % 4 == 0) ? 8'd0 : (i % 4 == 1) ? 8'd255 : 8'(i * 29 + 40);
            hw(3'd0, i, {a, 8'(i * 7 + 3), 8'(i * 53), 8'(255 - i * 5)});
        end
        hw(3'd2, 0, {16'd2, 16'd3});
        hw(3'd3, 0, {16'd4, 16'd8});
        hw(3'd4, 0, 32'd1);
        phase = "R4"; frame(2, -1);                  // R4 shadow only, not shown
        phase = "R3"; frame(3, -1);                  // R3 blended 8x4 cursor
        phase = "R8";
        hw(3'd2, 0, {16'hFFFF, 16'hFFFE});
        frame(4, -1); frame(5, -1);                  // R8 top-left clip offset
        hw(3'd2, 0, {16'd6, 16'd13});
        frame(6, -1); frame(7, -1);                  // R8 right/bottom cut
        phase = "R6";
        hw(3'd2, 0, {16'd1, 16'd2});
        hw(3'd3, 0, {16'd8, 16'd4});
        frame(8, -1); frame(9, -1);                  // R6 4 wide 8 high accepted
        hw(3'd3, 0, {16'd8, 16'd8});
        frame(10, -1); frame(11, -1);                // R6 both sides over SHORT
        hw(3'd3, 0, {16'd2, 16'd9});
        frame(12, -1); frame(13, -1);                // R6 width over LONG
        phase = "R9";
        hw(3'd3, 0, {16'd3, 16'd8});
        frame(14, -1);
        interlace = 1;
        frame(15, -1);                               // R9 one row of three
        hw(3'd3, 0, {16'd8, 16'd4});
        frame(16, -1); frame(17, -1);                // R9 four rows of eight
        interlace = 0;
        phase = "R10";
        hw(3'd3, 0, {16'd4, 16'd8});
        hw(3'd1, 0, 32'hE4E4_E4E4);
        hw(3'd1, 1, 32'h1B1B_1B1B);
        frame(18, -1); frame(19, -1);                // R10 all four codes
        phase = "R11";
        ram_sleep = 1;
        idle(3);
        hw(3'd1, 0, 32'h0);                          // R11 dropped while asleep
        frame(20, -1);                               // R11 hidden while asleep
        ram_sleep = 0;
        frame(21, -1);                               // R11 refill then default codes
        ram_sleep = 1;
        idle(2);
        ram_sleep = 0;
        hw(3'd1, 1, 32'h0);                          // R11 dropped during refill
        idle(8);
        frame(22, -1);
        phase = "R5";
        frame(23, 3);                                // R5 vanishes mid-frame
        frame(24, -1);
        hw(3'd3, 0, {16'd4, 16'd8});
        hw(3'd4, 0, 32'd1);
        phase = "R2";
        frame(25, -1); frame(26, -1);                // R2 timing and blanking
        idle(4);
        report();
    end

endmodule